// File: doc/BRIEF.md
# Continuous ADC frame SPI reader

This block is an SPI master that pulls one conversion frame out of a four-channel, 24-bit delta-sigma converter that runs in continuous-read mode. The converter signals a fresh sample by pulling its active-low data-ready line low. The reader waits for that falling edge and then lowers chip select. It runs 120 serial clocks in a single burst: a 24-bit status word comes first, then four 24-bit channel words. While the burst runs, the reader holds MOSI at zero and adds no filler bytes.

Once chip select has risen again, the reader checks the four-bit header of the status word. It sign-extends each channel word to 32 bits and presents all results together with a one-cycle valid strobe. A data-ready edge that arrives while a burst is still running is recorded as an overrun and starts nothing.

The controller is a four-state machine with these states and transitions:
- IDLE goes to LEAD on a detected data-ready fall, and chip select drops.
- LEAD goes to SHIFT after one half-period, on the first rising SCLK edge.
- SHIFT goes to TRAIL on the falling SCLK edge of bit 120.
- TRAIL goes to IDLE after one more half-period. Chip select rises and the results are published on that transition.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset (synchronous, active low) is held and in the first cycle after it is released, cs_n is high and sclk is low. frame_valid, hdr_err and overrun are low, and status_word and ch_words are zero.
- R2: A frame starts only on a high-to-low transition of drdy_n. drdy_n held low through reset, or held low after a frame has been read, starts no further frame.
- R3: Each frame has exactly 120 rising sclk edges inside one low period of cs_n, and mosi is 0 at all times.
- R4: sclk is low whenever cs_n is high. miso is sampled on the falling sclk edge, so a peripheral that changes miso on each rising edge is read without error.
- R5: Bits arrive MSB first. The first 24 bits form status_word. The next four 24-bit words go to channels 0 to 3, with channel k placed at ch_words[32k+31:32k].
- R6: Each channel output holds its 24-bit word in bits 23:0. Bits 31:24 are all ones when bit 23 is 1, and all zeros otherwise.
- R7: When frame_valid is high, hdr_err is 1 exactly when status_word[23:20] differs from 4'b1100.
- R8: With HALF = DIV/2 system clocks, cs_n falls HALF cycles before the first rising sclk edge. Every high and low phase of sclk lasts HALF cycles, and cs_n rises HALF cycles after the last falling edge.
- R9: A drdy_n fall that arrives while a frame is in progress sets overrun and starts no extra frame. The current frame still delivers its own data. overrun is cleared when the next frame starts.
- R10: frame_valid is high for exactly one system clock per frame, in the cycle after cs_n rises. status_word, ch_words and hdr_err change only together with that pulse and hold between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drdy_n | input | 1 | Active-low data-ready from the converter |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter, held at 0 |
| status_word | output | 24 | Status word of the last frame |
| ch_words | output | 128 | Four sign-extended 32-bit channel results |
| frame_valid | output | 1 | One-cycle strobe when new results are present |
| hdr_err | output | 1 | Status header mismatch for the last frame |
| overrun | output | 1 | A data-ready edge arrived during a frame |

## Verification
Several frame patterns exercise the reader. The first carries positive channel words, including the largest positive code and a mid-scale value. The second carries negative words, covering the most negative code and minus one, so that a fault in sign extension or word order cannot hide. Two frames with bad headers, 1101 and 0100, separate a full header compare from a single-bit test. Level-versus-edge detection is probed by holding data-ready low through reset and again after a frame. A second data-ready edge in the middle of a burst must raise the overrun flag while the frame's own data comes through intact, and the next frame must clear the flag.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } rd_state_t;

    localparam logic [3:0] HDR_PATTERN = 4'b1100;
endpackage

// File: rtl/drdy_fall_det.sv
module drdy_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic drdy_n,
    output logic fall
);
    logic sync1, sync2, last;

    // Registers start low, so a line that is already low at reset is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            last  <= 1'b0;
        end else begin
            sync1 <= drdy_n;
            sync2 <= sync1;
            last  <= sync2;
        end
    end

    assign fall = last & ~sync2;
endmodule

// File: rtl/half_tick_gen.sv
module half_tick_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int FRAME_BITS = 120
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic                  miso,
    output logic [FRAME_BITS-1:0] bits
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (shift_en) begin
            bits <= {bits[FRAME_BITS-2:0], miso};
        end
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_frame_pkg::*;
#(
    parameter int DIV    = 8,
    parameter int CH_NUM = 4,
    parameter int WORD_W = 24,
    parameter int OUT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    drdy_n,
    input  logic                    miso,
    output logic                    sclk,
    output logic                    cs_n,
    output logic                    mosi,
    output logic [WORD_W-1:0]       status_word,
    output logic [CH_NUM*OUT_W-1:0] ch_words,
    output logic                    frame_valid,
    output logic                    hdr_err,
    output logic                    overrun
);
    localparam int HALF       = DIV / 2;
    localparam int FRAME_BITS = (CH_NUM + 1) * WORD_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    rd_state_t state, next_state;
    logic drdy_fall, tick, shift_en, last_bit;
    logic [CNT_W-1:0] bit_cnt;
    logic [FRAME_BITS-1:0] frame_bits;
    logic [CH_NUM*OUT_W-1:0] ch_ext;
    logic [WORD_W-1:0] status_raw;

    assign mosi = 1'b0;

    drdy_fall_det u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .drdy_n (drdy_n),
        .fall   (drdy_fall)
    );

    half_tick_gen #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .tick  (tick)
    );

    // A falling sclk edge happens on a tick while sclk is high.
    assign shift_en = (state == ST_SHIFT) && tick && sclk;
    assign last_bit = (bit_cnt == LAST_BIT);

    frame_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .miso     (miso),
        .bits     (frame_bits)
    );

    assign status_raw = frame_bits[FRAME_BITS-1 -: WORD_W];

    for (genvar g = 0; g < CH_NUM; g++) begin : g_ext
        localparam int MSB = FRAME_BITS - 1 - WORD_W * (g + 1);
        logic [WORD_W-1:0] word;
        assign word = frame_bits[MSB -: WORD_W];
        assign ch_ext[g*OUT_W +: OUT_W] = {{(OUT_W - WORD_W){word[WORD_W-1]}}, word};
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // Transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:  if (drdy_fall)                 next_state = ST_LEAD;
            ST_LEAD:  if (tick)                      next_state = ST_SHIFT;
            ST_SHIFT: if (shift_en && last_bit)      next_state = ST_TRAIL;
            ST_TRAIL: if (tick)                      next_state = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk        <= 1'b0;
            cs_n        <= 1'b1;
            bit_cnt     <= '0;
            status_word <= '0;
            ch_words    <= '0;
            frame_valid <= 1'b0;
            hdr_err     <= 1'b0;
            overrun     <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (drdy_fall) begin
                        cs_n    <= 1'b0;
                        bit_cnt <= '0;
                        overrun <= 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (tick) sclk <= 1'b1;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        if (sclk) bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        cs_n        <= 1'b1;
                        frame_valid <= 1'b1;
                        status_word <= status_raw;
                        ch_words    <= ch_ext;
                        hdr_err     <= (status_raw[WORD_W-1 -: 4] != HDR_PATTERN);
                    end
                end
            endcase
            if (drdy_fall && state != ST_IDLE) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
    parameter int CH_NUM = 4,
    parameter int WORD_W = 24,
    parameter int OUT_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sclk,
    input logic                    cs_n,
    input logic                    mosi,
    input logic [WORD_W-1:0]       status_word,
    input logic [CH_NUM*OUT_W-1:0] ch_words,
    input logic                    frame_valid,
    input logic                    hdr_err
);
    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_mosi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mosi == 1'b0);

    p_cs_end_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> frame_valid);

    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(status_word) && $stable(ch_words) && $stable(hdr_err)));

    p_header_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (hdr_err == (status_word[WORD_W-1 -: 4] != 4'b1100)));

    for (genvar k = 0; k < CH_NUM; k++) begin : g_sx
        p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
            frame_valid |->
            (ch_words[k*OUT_W + WORD_W +: (OUT_W - WORD_W)] ==
             {(OUT_W - WORD_W){ch_words[k*OUT_W + WORD_W - 1]}}));
    end
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
    .CH_NUM (CH_NUM),
    .WORD_W (WORD_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .mosi        (mosi),
    .status_word (status_word),
    .ch_words    (ch_words),
    .frame_valid (frame_valid),
    .hdr_err     (hdr_err)
);

// File: tb/adc_frame_reader_test.sv
`timescale 1ns/1ps
module adc_frame_reader_test;
    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drdy_n = 1'b0;
    logic miso = 1'b0;
    logic sclk, cs_n, mosi, frame_valid, hdr_err, overrun;
    logic [23:0]  status_word;
    logic [127:0] ch_words;

    always #10 clk = ~clk;

    adc_frame_reader #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .miso(miso),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .status_word(status_word), .ch_words(ch_words),
        .frame_valid(frame_valid), .hdr_err(hdr_err), .overrun(overrun)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Peripheral model: new bit on each rising sclk edge, MSB first.
    logic [119:0] tx_bits = '0;
    int tx_idx = 119;
    int rises = 0;
    always @(posedge sclk or negedge cs_n) begin
        if (!sclk) begin
            tx_idx = 119;
            rises  = 0;
        end else if (!cs_n) begin
            miso = tx_bits[tx_idx];
            tx_idx = tx_idx - 1;
            rises = rises + 1;
        end
    end

    // Expected values for the frame in flight
    logic [23:0]  exp_status = '0;
    logic [127:0] exp_ch = '0;
    logic         exp_hdr = 1'b0;
    logic         exp_over = 1'b0;
    logic [23:0]  hold_status = '0;
    logic [127:0] hold_ch = '0;
    logic         hold_hdr = 1'b0;
    int valid_seen = 0;
    int cs_starts = 0;

    function automatic logic [31:0] sx(input logic [23:0] v);
        return v[23] ? {8'hFF, v} : {8'h00, v};
    endfunction

    // Per-clock comparison against the model
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_valid = 1'b0;
    int last_edge = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(!(cs_n && sclk), "R4 sclk idle low", {cs_n, sclk}, 2'b10);
            check(mosi == 1'b0, "R3 mosi low", mosi, 0);
            if (prev_cs && !cs_n) begin
                cs_starts++;
                last_edge = cyc;
            end
            if (!cs_n && sclk != prev_sclk) begin
                check(cyc - last_edge == HALF, "R8 half period", cyc - last_edge, HALF);
                last_edge = cyc;
            end
            if (!prev_cs && cs_n) begin
                check(cyc - last_edge == HALF, "R8 cs trail", cyc - last_edge, HALF);
                check(rises == 120, "R3 sclk count", rises, 120);
            end
            if (frame_valid) begin
                check(!prev_valid, "R10 single pulse", prev_valid, 0);
                check(status_word == exp_status, "R5 status", status_word, exp_status);
                check(ch_words == exp_ch, "R5 R6 channels", ch_words, exp_ch);
                check(hdr_err == exp_hdr, "R7 header", hdr_err, exp_hdr);
                check(overrun == exp_over, "R9 overrun", overrun, exp_over);
                hold_status = status_word;
                hold_ch = ch_words;
                hold_hdr = hdr_err;
                valid_seen++;
            end else begin
                check(status_word == hold_status && ch_words == hold_ch && hdr_err == hold_hdr,
                      "R10 hold", {hdr_err, status_word, ch_words[79:0]},
                      {hold_hdr, hold_status, hold_ch[79:0]});
            end
        end
        prev_cs = cs_n;
        prev_sclk = sclk;
        prev_valid = frame_valid;
    end

    task automatic send_frame(input logic [23:0] st, input logic [23:0] c0, input logic [23:0] c1,
                              input logic [23:0] c2, input logic [23:0] c3,
                              input bit inject, input bit sticky);
        int target;
        tx_bits    = {st, c0, c1, c2, c3};
        exp_status = st;
        exp_ch     = {sx(c3), sx(c2), sx(c1), sx(c0)};
        exp_hdr    = (st[23:20] != 4'b1100);
        exp_over   = inject;
        target     = valid_seen + 1;
        @(negedge clk);
        drdy_n = 1'b0;
        if (!sticky) begin
            @(negedge sclk);
            drdy_n = 1'b1;
        end
        if (inject) begin
            repeat (100) @(negedge clk);
            drdy_n = 1'b0;
            repeat (6) @(negedge clk);
            drdy_n = 1'b1;
        end
        wait (valid_seen == target);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        int starts;
        repeat (10) @(negedge clk);
        // R1: state during reset
        check(cs_n == 1'b1 && sclk == 1'b0, "R1 lines in reset", {cs_n, sclk}, 2'b10);
        check({frame_valid, hdr_err, overrun} == 3'b000, "R1 flags in reset",
              {frame_valid, hdr_err, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && status_word == 0 && ch_words == 0,
              "R1 after release", {cs_n, sclk, status_word}, {2'b10, 24'h0});
        check(overrun == 1'b0, "R1 overrun clear", overrun, 0);
        // R2: drdy low through reset starts nothing
        repeat (300) @(negedge clk);
        check(cs_starts == 0, "R2 level low no start", cs_starts, 0);
        drdy_n = 1'b1;
        repeat (10) @(negedge clk);

        // R5 positive words
        send_frame(24'hC000A5, 24'h470F4D, 24'h000001, 24'h7FFFFF, 24'h123456, 0, 0);
        // R6 negative words
        send_frame(24'hC12345, 24'h800000, 24'hFFFFFF, 24'hF0000F, 24'hABCDEF, 0, 0);
        // R7 bad headers
        send_frame(24'hD00000, 24'h000000, 24'h800001, 24'h5A5A5A, 24'hA5A5A5, 0, 0);
        send_frame(24'h400000, 24'h7FFFFE, 24'h000002, 24'hFF0000, 24'h00FF00, 0, 0);
        // R9 overrun during frame
        starts = cs_starts;
        send_frame(24'hCFFFFF, 24'h111111, 24'h999999, 24'h222222, 24'hEEEEEE, 1, 0);
        repeat (300) @(negedge clk);
        check(cs_starts == starts + 1, "R9 no extra frame", cs_starts, starts + 1);
        check(overrun == 1'b1, "R9 overrun held", overrun, 1);
        // R9 cleared by next frame
        send_frame(24'hC0FFEE, 24'h000010, 24'hFFFFF0, 24'h400000, 24'hC00000, 0, 0);
        // R2 drdy held low after frame
        starts = cs_starts;
        send_frame(24'hCABCDE, 24'h765432, 24'h89ABCD, 24'h000000, 24'hFFFFFE, 0, 1);
        repeat (400) @(negedge clk);
        check(cs_starts == starts + 1, "R2 level low after frame", cs_starts, starts + 1);
        drdy_n = 1'b1;
        repeat (20) @(negedge clk);
        check(valid_seen == 7, "R10 frame count", valid_seen, 7);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule